// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps two sticky status flags for a FIFO-buffered UART: a receive-error flag and a transmit-end flag. The serial core sends it single-cycle events. One event says a received frame has finished, and it carries the data bits, the parity bit and the sampled stop bit. Another says the last bit of a character has left the shifter, and it arrives together with the transmit-FIFO-empty level. Two more report writes into the transmit FIFO, one from the CPU and one from a DMA engine. The block checks parity and framing on each received frame. It pushes the byte and its per-byte error tags toward the receive FIFO whether or not the frame was good. It sets and clears the flags according to the enable bits and to software.

Software reads both flags through a small status port. It clears a flag with a handshake: it first reads the flag as 1, then writes 0 to it. Writing 1 does nothing. A write of 0 that was not preceded by a read of 1 also does nothing. The transmit-end flag has extra rules. It is cleared at once by any DMA write into the transmit FIFO, and it is pinned to 1 while the transmitter is disabled.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the receive-error flag is 0 and the transmit-end flag is 1. Status bit 0 is the receive-error flag and status bit 1 is the transmit-end flag, on both `cpu_rdata` and `cpu_wdata`.
- R2: A finished frame whose stop bit is 0, received while the receiver is enabled, sets the receive-error flag from the next cycle on.
- R3: With parity checking enabled, a frame sets the receive-error flag when the XOR of its data bits and parity bit differs from `par_odd` (0 selects even, 1 selects odd). With parity checking disabled, no parity error is ever reported.
- R4: Each frame finished while the receiver is enabled is pushed one cycle later on `rx_push`, together with its data and a framing tag (`rx_push_fer`) and a parity tag (`rx_push_per`). Frames with errors are pushed too.
- R5: While `rx_en` is 0 the receive-error flag holds its value: frames neither set it nor get pushed, and a software clear has no effect.
- R6: The receive-error flag goes to 0 only on a CPU write of 0 to bit 0 that follows a CPU read returning that bit as 1. Any write to the port uses up the earlier read. Writing 1, or writing 0 without such a read, leaves the flag unchanged.
- R7: When the last bit of a character is shifted out while the transmit FIFO is empty, the transmit-end flag is set. If the FIFO is not empty at that point, the flag is not set.
- R8: While `tx_en` is 0 the transmit-end flag reads 1, whatever else happens.
- R9: A software clear of the transmit-end flag (read of 1, then write of 0 to bit 1) takes effect only if the CPU has written into the transmit FIFO since the flag was last set. Without such a write the flag stays 1.
- R10: With the transmitter enabled, a DMA write into the transmit FIFO clears the transmit-end flag in the next cycle, with no handshake needed.
- R11: If a set event and a valid clear of the same flag fall in one cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on or manual) |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| rx_frame_done | input | 1 | Pulse: a received frame has ended |
| rx_data | input | DATA_W | Data bits of the finished frame |
| rx_par_bit | input | 1 | Received parity bit |
| rx_stop_bit | input | 1 | Sampled stop bit |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| tx_last_bit | input | 1 | Pulse: last bit of a character shifted out |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_fifo_wr_cpu | input | 1 | Pulse: CPU write into transmit FIFO |
| tx_fifo_wr_dma | input | 1 | Pulse: DMA write into transmit FIFO |
| cpu_rd | input | 1 | Status register read strobe |
| cpu_wr | input | 1 | Status register write strobe |
| cpu_wdata | input | 2 | Write data (bit 0 receive error, bit 1 transmit end) |
| cpu_rdata | output | 2 | Current flags (bit 0 receive error, bit 1 transmit end) |
| rx_push | output | 1 | Pulse: push a byte into the receive FIFO |
| rx_push_data | output | DATA_W | Byte being pushed |
| rx_push_fer | output | 1 | Framing-error tag of the pushed byte |
| rx_push_per | output | 1 | Parity-error tag of the pushed byte |

## Verification
The parity and framing check is driven by a table of frames. The table covers even and odd sense with an even and an odd number of ones, parity checking switched off while the parity bit is wrong, and stop-bit errors alone and together with parity errors. Each row tells a correct parity XOR apart from an inverted sense or a missing enable gate. The flag handshake is then tried in several orders: write without a read, a write of 1 after a read, a proper read and write, and a clear that coincides with a set. These separate a working "seen" latch from a plain write-0-to-clear. The transmit side is exercised with and without a prior CPU FIFO write, with a DMA write, with a last bit sent while the FIFO still holds data, and with the transmitter disabled. This exposes the wrong priority among force, set and clear.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

    localparam int FLAG_N    = 2;
    localparam int RXERR_IDX = 0;
    localparam int TXEND_IDX = 1;

    typedef struct packed {
        logic fer;
        logic per;
    } rx_tag_t;

    typedef logic [FLAG_N-1:0] flag_vec_t;

    // Mismatch between the parity seen on the line and the selected sense.
    function automatic logic par_mismatch(input logic data_xor,
                                          input logic par_bit,
                                          input logic odd_sel);
        return ((data_xor ^ par_bit) != odd_sel);
    endfunction

endpackage

// File: rtl/uart_rx_check.sv
module uart_rx_check
    import uart_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] data,
    input  logic              par_bit,
    input  logic              stop_bit,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              err_evt,
    output logic              push_vld,
    output logic [DATA_W-1:0] push_data,
    output rx_tag_t           push_tag
);

    rx_tag_t tag_now;
    logic    accept;

    assign accept = rx_en && frame_done;

    always_comb begin
        tag_now.fer = !stop_bit;
        tag_now.per = par_en && par_mismatch(^data, par_bit, par_odd);
    end

    assign err_evt = accept && (tag_now.fer || tag_now.per);

    always_ff @(posedge clk) begin
        if (rst) begin
            push_vld  <= 1'b0;
            push_data <= '0;
            push_tag  <= '0;
        end else begin
            push_vld <= accept;
            if (accept) begin
                push_data <= data;
                push_tag  <= tag_now;
            end
        end
    end

endmodule

// File: rtl/uart_clr_hshake.sv
module uart_clr_hshake (
    input  logic clk,
    input  logic rst,
    input  logic rd,
    input  logic wr,
    input  logic wbit,
    input  logic flag,
    output logic clr_ok
);

    logic seen_q;

    assign clr_ok = wr && !wbit && seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
        end else if (wr) begin
            seen_q <= 1'b0;
        end else if (rd && flag) begin
            seen_q <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_err_flag.sv
module uart_rx_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic set_evt,
    input  logic clr_ok,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (en) begin
            if (set_evt) begin
                flag <= 1'b1;
            end else if (clr_ok) begin
                flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_tx_end_flag.sv
module uart_tx_end_flag (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic last_bit,
    input  logic fifo_empty,
    input  logic cpu_fifo_wr,
    input  logic dma_fifo_wr,
    input  logic clr_ok,
    output logic flag
);

    logic set_evt;
    logic data_wr_q;
    logic sw_clear;
    logic flag_nx;

    assign set_evt  = last_bit && fifo_empty;
    assign sw_clear = clr_ok && (data_wr_q || cpu_fifo_wr);

    always_comb begin
        flag_nx = flag;
        if (!en) begin
            flag_nx = 1'b1;
        end else if (set_evt) begin
            flag_nx = 1'b1;
        end else if (dma_fifo_wr || sw_clear) begin
            flag_nx = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag      <= 1'b1;
            data_wr_q <= 1'b0;
        end else begin
            flag <= flag_nx;
            if (!en || set_evt || (flag && !flag_nx)) begin
                data_wr_q <= 1'b0;
            end else if (cpu_fifo_wr) begin
                data_wr_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
    import uart_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              rx_frame_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_bit,
    input  logic              rx_stop_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              tx_last_bit,
    input  logic              tx_fifo_empty,
    input  logic              tx_fifo_wr_cpu,
    input  logic              tx_fifo_wr_dma,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_wdata,
    output logic [1:0]        cpu_rdata,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_push_data,
    output logic              rx_push_fer,
    output logic              rx_push_per
);

    flag_vec_t flags;
    flag_vec_t clr_ok;
    logic      rx_err_evt;
    rx_tag_t   push_tag;

    uart_rx_check #(.DATA_W(DATA_W)) u_rx_check (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .frame_done (rx_frame_done),
        .data       (rx_data),
        .par_bit    (rx_par_bit),
        .stop_bit   (rx_stop_bit),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .err_evt    (rx_err_evt),
        .push_vld   (rx_push),
        .push_data  (rx_push_data),
        .push_tag   (push_tag)
    );

    assign rx_push_fer = push_tag.fer;
    assign rx_push_per = push_tag.per;

    for (genvar g = 0; g < FLAG_N; g++) begin : g_hshake
        uart_clr_hshake u_hs (
            .clk    (clk),
            .rst    (rst),
            .rd     (cpu_rd),
            .wr     (cpu_wr),
            .wbit   (cpu_wdata[g]),
            .flag   (flags[g]),
            .clr_ok (clr_ok[g])
        );
    end

    uart_rx_err_flag u_rx_flag (
        .clk     (clk),
        .rst     (rst),
        .en      (rx_en),
        .set_evt (rx_err_evt),
        .clr_ok  (clr_ok[RXERR_IDX]),
        .flag    (flags[RXERR_IDX])
    );

    uart_tx_end_flag u_tx_flag (
        .clk         (clk),
        .rst         (rst),
        .en          (tx_en),
        .last_bit    (tx_last_bit),
        .fifo_empty  (tx_fifo_empty),
        .cpu_fifo_wr (tx_fifo_wr_cpu),
        .dma_fifo_wr (tx_fifo_wr_dma),
        .clr_ok      (clr_ok[TXEND_IDX]),
        .flag        (flags[TXEND_IDX])
    );

    assign cpu_rdata = flags;

endmodule

// File: rtl/uart_flag_ctrl_chk.sv
module uart_flag_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       tx_en,
    input logic       rx_frame_done,
    input logic       rx_stop_bit,
    input logic       tx_last_bit,
    input logic       tx_fifo_empty,
    input logic       tx_fifo_wr_dma,
    input logic       cpu_wr,
    input logic [1:0] cpu_wdata,
    input logic [1:0] cpu_rdata,
    input logic       rx_push
);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cpu_rdata == 2'b10));

    // R2 and R11: a stop-bit error always leaves the flag set
    a_r2_stop_err_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_en && rx_frame_done && !rx_stop_bit) |=> cpu_rdata[0]);

    // R4 and R5: a push follows exactly the accepted frames
    a_r4_push_follows_frame: assert property (@(posedge clk) disable iff (rst)
        (rx_en && rx_frame_done) |=> rx_push);

    a_r5_no_push_when_off: assert property (@(posedge clk) disable iff (rst)
        !(rx_en && rx_frame_done) |=> !rx_push);

    a_r5_frozen_flag: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> $stable(cpu_rdata[0]));

    // R6: a fall needs a write of 0 to bit 0
    a_r6_fall_needs_write0: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rdata[0]) |-> $past(cpu_wr && !cpu_wdata[0]));

    // R7
    a_r7_tx_set: assert property (@(posedge clk) disable iff (rst)
        (tx_last_bit && tx_fifo_empty) |=> cpu_rdata[1]);

    // R8
    a_r8_tx_forced: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> cpu_rdata[1]);

    // R10
    a_r10_dma_clear: assert property (@(posedge clk) disable iff (rst)
        (tx_en && tx_fifo_wr_dma && !(tx_last_bit && tx_fifo_empty)) |=> !cpu_rdata[1]);

endmodule

bind uart_flag_ctrl uart_flag_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .rx_en          (rx_en),
    .tx_en          (tx_en),
    .rx_frame_done  (rx_frame_done),
    .rx_stop_bit    (rx_stop_bit),
    .tx_last_bit    (tx_last_bit),
    .tx_fifo_empty  (tx_fifo_empty),
    .tx_fifo_wr_dma (tx_fifo_wr_dma),
    .cpu_wr         (cpu_wr),
    .cpu_wdata      (cpu_wdata),
    .cpu_rdata      (cpu_rdata),
    .rx_push        (rx_push)
);

// File: tb/uart_flag_ctrl_bench.sv
`timescale 1ns/1ps
module uart_flag_ctrl_bench;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          rx_en, tx_en, rx_frame_done, rx_par_bit, rx_stop_bit;
    logic [DW-1:0] rx_data;
    logic          par_en, par_odd, tx_last_bit, tx_fifo_empty;
    logic          tx_fifo_wr_cpu, tx_fifo_wr_dma, cpu_rd, cpu_wr;
    logic [1:0]    cpu_wdata, cpu_rdata;
    logic          rx_push, rx_push_fer, rx_push_per;
    logic [DW-1:0] rx_push_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    uart_flag_ctrl #(.DATA_W(DW)) u_uart_flag_ctrl (
        .clk(clk), .rst(rst), .rx_en(rx_en), .tx_en(tx_en),
        .rx_frame_done(rx_frame_done), .rx_data(rx_data),
        .rx_par_bit(rx_par_bit), .rx_stop_bit(rx_stop_bit),
        .par_en(par_en), .par_odd(par_odd), .tx_last_bit(tx_last_bit),
        .tx_fifo_empty(tx_fifo_empty), .tx_fifo_wr_cpu(tx_fifo_wr_cpu),
        .tx_fifo_wr_dma(tx_fifo_wr_dma), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rx_push(rx_push),
        .rx_push_data(rx_push_data), .rx_push_fer(rx_push_fer),
        .rx_push_per(rx_push_per)
    );

    typedef struct packed {
        logic [DW-1:0] data;
        logic          par;
        logic          stop;
        logic          pen;
        logic          odd;
        logic          fer;
        logic          per;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'h03, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{8'h07, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [DW-1:0] d, input logic p, input logic s);
        rx_frame_done = 1'b1; rx_data = d; rx_par_bit = p; rx_stop_bit = s;
        tick();
        rx_frame_done = 1'b0; rx_stop_bit = 1'b1;
    endtask

    task automatic sw_read();
        cpu_rd = 1'b1;
        tick();
        cpu_rd = 1'b0;
    endtask

    task automatic sw_write(input logic [1:0] w);
        cpu_wr = 1'b1; cpu_wdata = w;
        tick();
        cpu_wr = 1'b0; cpu_wdata = 2'b11;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic exp_rx;
        rst = 1'b1; rx_en = 1'b1; tx_en = 1'b1; rx_frame_done = 1'b0;
        rx_data = '0; rx_par_bit = 1'b0; rx_stop_bit = 1'b1;
        par_en = 1'b1; par_odd = 1'b0; tx_last_bit = 1'b0; tx_fifo_empty = 1'b1;
        tx_fifo_wr_cpu = 1'b0; tx_fifo_wr_dma = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        cpu_wdata = 2'b11;
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 reset flags", {6'd0, cpu_rdata}, 8'h02);
        chk("R1 no push", {7'd0, rx_push}, 8'h00);

        // Frame table: R2, R3, R4
        exp_rx = 1'b0;
        for (int i = 0; i < 8; i++) begin
            par_en = VECS[i].pen; par_odd = VECS[i].odd;
            frame(VECS[i].data, VECS[i].par, VECS[i].stop);
            exp_rx = exp_rx | VECS[i].fer | VECS[i].per;
            chk("R4 push strobe", {7'd0, rx_push}, 8'h01);
            chk("R4 push data", rx_push_data, VECS[i].data);
            chk("R2 framing tag", {7'd0, rx_push_fer}, {7'd0, VECS[i].fer});
            chk("R3 parity tag", {7'd0, rx_push_per}, {7'd0, VECS[i].per});
            chk("R2/R3 rx flag", {7'd0, cpu_rdata[0]}, {7'd0, exp_rx});
        end
        tick();
        chk("R4 push is a pulse", {7'd0, rx_push}, 8'h00);

        // R6 handshake orders
        sw_write(2'b10);
        chk("R6 write0 without read", {7'd0, cpu_rdata[0]}, 8'h01);
        sw_read();
        sw_write(2'b11);
        chk("R6 write1 after read", {7'd0, cpu_rdata[0]}, 8'h01);
        sw_write(2'b10);
        chk("R6 read consumed by write", {7'd0, cpu_rdata[0]}, 8'h01);
        sw_read();
        sw_write(2'b10);
        chk("R6 read then write0 clears", {7'd0, cpu_rdata[0]}, 8'h00);

        // R5 receiver disabled
        rx_en = 1'b0;
        frame(8'h11, 1'b0, 1'b0);
        chk("R5 no set when off", {7'd0, cpu_rdata[0]}, 8'h00);
        chk("R5 no push when off", {7'd0, rx_push}, 8'h00);
        rx_en = 1'b1;
        frame(8'h22, 1'b0, 1'b0);
        chk("R2 set after re-enable", {7'd0, cpu_rdata[0]}, 8'h01);
        sw_read();
        rx_en = 1'b0;
        sw_write(2'b10);
        chk("R5 clear ignored when off", {7'd0, cpu_rdata[0]}, 8'h01);
        rx_en = 1'b1;

        // R11 set and clear together
        sw_read();
        cpu_wr = 1'b1; cpu_wdata = 2'b10;
        frame(8'h33, 1'b1, 1'b0);
        cpu_wr = 1'b0; cpu_wdata = 2'b11;
        chk("R11 set wins over clear", {7'd0, cpu_rdata[0]}, 8'h01);

        // Transmit side: R9, R7, R10, R8
        chk("R1 tx end high", {7'd0, cpu_rdata[1]}, 8'h01);
        sw_read();
        sw_write(2'b01);
        chk("R9 no clear without fifo write", {7'd0, cpu_rdata[1]}, 8'h01);
        tx_fifo_wr_cpu = 1'b1; tick(); tx_fifo_wr_cpu = 1'b0;
        sw_read();
        sw_write(2'b01);
        chk("R9 clear after fifo write", {7'd0, cpu_rdata[1]}, 8'h00);
        tx_fifo_empty = 1'b0; tx_last_bit = 1'b1; tick(); tx_last_bit = 1'b0;
        chk("R7 no set with data left", {7'd0, cpu_rdata[1]}, 8'h00);
        tx_fifo_empty = 1'b1; tx_last_bit = 1'b1; tick(); tx_last_bit = 1'b0;
        chk("R7 set when fifo empty", {7'd0, cpu_rdata[1]}, 8'h01);
        tx_fifo_wr_dma = 1'b1; tick(); tx_fifo_wr_dma = 1'b0;
        chk("R10 dma write clears", {7'd0, cpu_rdata[1]}, 8'h00);
        tx_en = 1'b0; tick();
        chk("R8 forced high when off", {7'd0, cpu_rdata[1]}, 8'h01);
        tx_fifo_wr_dma = 1'b1; tick(); tx_fifo_wr_dma = 1'b0;
        chk("R8 dma ignored when off", {7'd0, cpu_rdata[1]}, 8'h01);
        tx_en = 1'b1;
        tx_fifo_wr_cpu = 1'b1; tick(); tx_fifo_wr_cpu = 1'b0;
        sw_read();
        cpu_wr = 1'b1; cpu_wdata = 2'b01; tx_last_bit = 1'b1;
        tick();
        cpu_wr = 1'b0; cpu_wdata = 2'b11; tx_last_bit = 1'b0;
        chk("R11 tx set wins", {7'd0, cpu_rdata[1]}, 8'h01);

        // R1 reset again from a non-reset state
        rst = 1'b1; tick(); rst = 1'b0;
        chk("R1 reset restores flags", {6'd0, cpu_rdata}, 8'h02);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule